// File: doc/BRIEF.md
# Split-Mode Translation Lookaside Buffer

This block caches virtual-to-physical page translations in two arrays that never share entries: one serves supervisor accesses and the other serves user accesses. Each entry holds a virtual page tag, a physical frame number, a read-only flag and a cache-inhibit flag. A lookup presents a virtual page number and a mode bit. In the same cycle the block returns hit or miss and the contents of the matching entry. Both arrays are direct-mapped. The low bits of the virtual page number select the entry, and the remaining bits form the tag.

Entries are written from a page-walker response. They are discarded through side effects of control accesses:
- A read of the translation-control register clears both arrays.
- A write of zero to that register clears the user array only.
- A write of 0x8000 to that register clears the supervisor array only.
- Reloading the user root pointer clears the user array, and reloading the supervisor root pointer clears the supervisor array.
- A bus write in the purge address space removes one page from both arrays.

Top module: `split_tlb`

## Requirements
- R1: After reset, every lookup misses in both modes.
- R2: A refill becomes visible from the next cycle. A lookup in the same mode with the same virtual page then hits and returns, in the lookup cycle, the frame, the read-only flag and the cache-inhibit flag that were written. A lookup of that page in the other mode misses.
- R3: The entry index is the low IDX_W bits of the virtual page number (4 bits by default). A refill replaces whatever entry sat at that index. A lookup whose upper bits differ from the stored tag misses.
- R4: A one-cycle pulse on `ctl_rd` invalidates every entry of both arrays.
- R5: A `ctl_wr` with `ctl_wdata` equal to 0x00000000 invalidates only the user array. A `ctl_wr` with `ctl_wdata` equal to 0x00008000 invalidates only the supervisor array. Any other written value changes no entry.
- R6: A pulse on `root_wr_user` invalidates the user array only. A pulse on `root_wr_super` invalidates the supervisor array only.
- R7: A bus write (`bus_wr`) with function code `bus_fc` equal to 3 invalidates the entry for `bus_vpn` in both arrays, and only where the stored tag matches. Entries at the same index with another tag are kept. Writes with any other function code change no entry.
- R8: When an invalidation that covers an entry falls in the same cycle as a refill of that entry, the entry ends invalid. The invalidation can be a flush of that array or a purge of the same page. A flush of the other array does not block the refill. A purge of an older page at the same index does not block the refill of a new page there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_super | input | 1 | Lookup mode: 1 supervisor, 0 user |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_pfn | output | PFN_W | Physical frame of the hit entry |
| lk_ro | output | 1 | Read-only flag of the hit entry |
| lk_ci | output | 1 | Cache-inhibit flag of the hit entry |
| fill_en | input | 1 | Walker response: write one entry |
| fill_super | input | 1 | Array to refill: 1 supervisor, 0 user |
| fill_vpn | input | VPN_W | Virtual page of the refill |
| fill_pfn | input | PFN_W | Physical frame of the refill |
| fill_ro | input | 1 | Read-only flag of the refill |
| fill_ci | input | 1 | Cache-inhibit flag of the refill |
| ctl_rd | input | 1 | Read strobe of the translation-control register |
| ctl_wr | input | 1 | Write strobe of the translation-control register |
| ctl_wdata | input | 32 | Value written to the translation-control register |
| root_wr_user | input | 1 | User root pointer register written |
| root_wr_super | input | 1 | Supervisor root pointer register written |
| bus_wr | input | 1 | Data write seen on the bus |
| bus_fc | input | 3 | Function code of the bus write |
| bus_vpn | input | VPN_W | Virtual page of the bus write |

## Verification
The case that needs care is a refill that falls in the same cycle as an invalidation. The bench provokes it by raising `fill_en` together with a control-register read, with a root-pointer write, or with a purge write to the same page. The same checks are repeated with a flush of the other array, and with a purge of the previous occupant of the refilled index. The result is judged by a lookup one cycle later. It must miss where the invalidation covers the new entry, and it must hit with the refilled frame where it does not.

// File: rtl/split_tlb_pkg.sv
package split_tlb_pkg;

    localparam int          CTL_W          = 32;
    localparam logic [31:0] CTL_DROP_USER  = 32'h0000_0000;
    localparam logic [31:0] CTL_DROP_SUPER = 32'h0000_8000;
    localparam logic [2:0]  FC_PURGE       = 3'd3;

    // One strobe per array: bit 0 user, bit 1 supervisor
    typedef struct packed {
        logic super_m;
        logic user_m;
    } mode_pair_t;

    typedef struct packed {
        logic ro;
        logic ci;
    } page_attr_t;

    function automatic logic is_purge(input logic wr, input logic [2:0] fc);
        return wr && (fc == FC_PURGE);
    endfunction

endpackage

// File: rtl/tlb_inval_decode.sv
module tlb_inval_decode
    import split_tlb_pkg::*;
(
    input  logic             ctl_rd,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             root_wr_user,
    input  logic             root_wr_super,
    input  logic             bus_wr,
    input  logic [2:0]       bus_fc,
    output mode_pair_t       flush,
    output logic             purge
);
    logic wr_user, wr_super;

    always_comb begin
        wr_user       = ctl_wr && (ctl_wdata == CTL_DROP_USER);
        wr_super      = ctl_wr && (ctl_wdata == CTL_DROP_SUPER);
        flush.user_m  = ctl_rd || wr_user || root_wr_user;
        flush.super_m = ctl_rd || wr_super || root_wr_super;
        purge         = is_purge(bus_wr, bus_fc);
    end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
    import split_tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             purge,
    input  logic [VPN_W-1:0] purge_vpn,
    input  logic             fill,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  page_attr_t       fill_attr,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] pfn,
    output page_attr_t       attr
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = VPN_W - IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [DEPTH];
    logic [PFN_W-1:0] pfn_q  [DEPTH];
    page_attr_t       attr_q [DEPTH];

    logic [IDX_W-1:0] f_idx, p_idx, l_idx;
    logic [TAG_W-1:0] f_tag, p_tag, l_tag;
    logic             purge_kill;

    always_comb begin
        f_idx = fill_vpn[IDX_W-1:0];
        f_tag = fill_vpn[VPN_W-1:IDX_W];
        p_idx = purge_vpn[IDX_W-1:0];
        p_tag = purge_vpn[VPN_W-1:IDX_W];
        l_idx = lk_vpn[IDX_W-1:0];
        l_tag = lk_vpn[VPN_W-1:IDX_W];
        // A refill at the purged index replaces the old entry, so only
        // the incoming page is compared against the purge target then.
        if (fill && (f_idx == p_idx))
            purge_kill = purge && (f_tag == p_tag);
        else
            purge_kill = purge && valid_q[p_idx] && (tag_q[p_idx] == p_tag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (fill) begin
                valid_q[f_idx] <= 1'b1;
                tag_q[f_idx]   <= f_tag;
                pfn_q[f_idx]   <= fill_pfn;
                attr_q[f_idx]  <= fill_attr;
            end
            if (purge_kill)
                valid_q[p_idx] <= 1'b0;
            if (flush)
                valid_q <= '0;
        end
    end

    always_comb begin
        hit  = valid_q[l_idx] && (tag_q[l_idx] == l_tag);
        pfn  = pfn_q[l_idx];
        attr = attr_q[l_idx];
    end
endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import split_tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_super,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_ro,
    output logic             lk_ci,
    input  logic             fill_en,
    input  logic             fill_super,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_ro,
    input  logic             fill_ci,
    input  logic             ctl_rd,
    input  logic             ctl_wr,
    input  logic [31:0]      ctl_wdata,
    input  logic             root_wr_user,
    input  logic             root_wr_super,
    input  logic             bus_wr,
    input  logic [2:0]       bus_fc,
    input  logic [VPN_W-1:0] bus_vpn
);
    localparam int MODES = 2;

    mode_pair_t       flush;
    logic             purge;
    logic [MODES-1:0] flush_v, fill_v, b_hit;
    logic [PFN_W-1:0] b_pfn  [MODES];
    page_attr_t       b_attr [MODES];
    page_attr_t       in_attr, sel_attr;

    tlb_inval_decode u_dec (
        .ctl_rd        (ctl_rd),
        .ctl_wr        (ctl_wr),
        .ctl_wdata     (ctl_wdata),
        .root_wr_user  (root_wr_user),
        .root_wr_super (root_wr_super),
        .bus_wr        (bus_wr),
        .bus_fc        (bus_fc),
        .flush         (flush),
        .purge         (purge)
    );

    always_comb begin
        flush_v    = {flush.super_m, flush.user_m};
        fill_v     = {fill_en && fill_super, fill_en && !fill_super};
        in_attr.ro = fill_ro;
        in_attr.ci = fill_ci;
    end

    for (genvar m = 0; m < MODES; m++) begin : g_bank
        tlb_bank #(.VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush_v[m]),
            .purge     (purge),
            .purge_vpn (bus_vpn),
            .fill      (fill_v[m]),
            .fill_vpn  (fill_vpn),
            .fill_pfn  (fill_pfn),
            .fill_attr (in_attr),
            .lk_vpn    (lk_vpn),
            .hit       (b_hit[m]),
            .pfn       (b_pfn[m]),
            .attr      (b_attr[m])
        );
    end

    always_comb begin
        lk_hit   = b_hit[lk_super];
        lk_pfn   = b_pfn[lk_super];
        sel_attr = b_attr[lk_super];
        lk_ro    = sel_attr.ro;
        lk_ci    = sel_attr.ci;
    end
endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_super,
    input logic             lk_hit,
    input logic [PFN_W-1:0] lk_pfn,
    input logic             lk_ro,
    input logic             lk_ci,
    input logic             fill_en,
    input logic             fill_super,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PFN_W-1:0] fill_pfn,
    input logic             fill_ro,
    input logic             fill_ci,
    input logic             ctl_rd,
    input logic             ctl_wr,
    input logic [31:0]      ctl_wdata,
    input logic             root_wr_user,
    input logic             root_wr_super,
    input logic             bus_wr,
    input logic [2:0]       bus_fc,
    input logic [VPN_W-1:0] bus_vpn
);
    logic quiet;
    assign quiet = !ctl_rd && !ctl_wr && !root_wr_user && !root_wr_super
                   && !(bus_wr && bus_fc == 3'd3);

    // R2
    refill_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fill_en) && $past(quiet) && lk_vpn == $past(fill_vpn)
         && lk_super == $past(fill_super))
        |-> (lk_hit && lk_pfn == $past(fill_pfn)
             && lk_ro == $past(fill_ro) && lk_ci == $past(fill_ci)));

    // R4
    read_flush_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_rd |=> !lk_hit);

    // R5
    user_flush_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl_wr && ctl_wdata == 32'h0) || root_wr_user) |=> !(lk_hit && !lk_super));

    // R6
    super_flush_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl_wr && ctl_wdata == 32'h8000) || root_wr_super) |=> !(lk_hit && lk_super));

    // R7
    purge_page_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_fc == 3'd3) |=> !(lk_hit && lk_vpn == $past(bus_vpn)));
endmodule

bind split_tlb split_tlb_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) chk_i (.*);

// File: tb/split_tlb_tb_top.sv
module split_tlb_tb_top;
    localparam int VPN_W = 20;
    localparam int PFN_W = 20;

    logic             clk = 1'b0;
    logic             rst;
    logic [VPN_W-1:0] lk_vpn;
    logic             lk_super;
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic             lk_ro, lk_ci;
    logic             fill_en, fill_super, fill_ro, fill_ci;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;
    logic             ctl_rd, ctl_wr;
    logic [31:0]      ctl_wdata;
    logic             root_wr_user, root_wr_super, bus_wr;
    logic [2:0]       bus_fc;
    logic [VPN_W-1:0] bus_vpn;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    split_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(4)) dut_i (.*);

    task automatic idle();
        fill_en = 0; fill_super = 0; fill_vpn = '0; fill_pfn = '0;
        fill_ro = 0; fill_ci = 0; ctl_rd = 0; ctl_wr = 0; ctl_wdata = '0;
        root_wr_user = 0; root_wr_super = 0; bus_wr = 0; bus_fc = 3'd0;
        bus_vpn = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic set_fill(input bit s, input int vpn, input int pfn,
                            input bit ro, input bit ci);
        fill_en = 1; fill_super = s; fill_vpn = VPN_W'(vpn);
        fill_pfn = PFN_W'(pfn); fill_ro = ro; fill_ci = ci;
    endtask

    task automatic do_fill(input bit s, input int vpn, input int pfn,
                           input bit ro, input bit ci);
        set_fill(s, vpn, pfn, ro, ci);
        step();
    endtask

    task automatic look(input bit s, input int vpn, input bit eh, input int ep,
                        input bit ero, input bit eci, input string req);
        logic [PFN_W+2:0] act, exp;
        lk_super = s; lk_vpn = VPN_W'(vpn);
        #1;
        checks++;
        act = eh ? {lk_hit, lk_pfn, lk_ro, lk_ci} : {lk_hit, {(PFN_W+2){1'b0}}};
        exp = {eh, eh ? PFN_W'(ep) : {PFN_W{1'b0}}, eh && ero, eh && eci};
        if (act !== exp) begin
            errors++;
            $display("FAIL %s mode=%0d vpn=%h actual=%h expected=%h",
                     req, s, vpn, act, exp);
        end
    endtask

    task automatic fill_pair();
        do_fill(0, 'h12345, 'hABCDE, 1, 0);
        do_fill(1, 'h12345, 'h11111, 0, 1);
    endtask

    task automatic t_reset();
        look(0, 'h00005, 0, 0, 0, 0, "R1");
        look(1, 'h00005, 0, 0, 0, 0, "R1");
    endtask

    task automatic t_fill();
        do_fill(0, 'h12345, 'hABCDE, 1, 0);
        look(0, 'h12345, 1, 'hABCDE, 1, 0, "R2");
        look(1, 'h12345, 0, 0, 0, 0, "R2");
        do_fill(1, 'h12345, 'h11111, 0, 1);
        look(1, 'h12345, 1, 'h11111, 0, 1, "R2");
        look(0, 'h12345, 1, 'hABCDE, 1, 0, "R2");
    endtask

    task automatic t_index();
        do_fill(0, 'h00013, 'h00003, 0, 0);
        look(0, 'h00023, 0, 0, 0, 0, "R3");
        do_fill(0, 'h00023, 'h00004, 0, 1);
        look(0, 'h00013, 0, 0, 0, 0, "R3");
        look(0, 'h00023, 1, 'h00004, 0, 1, "R3");
    endtask

    task automatic t_ctl_read();
        fill_pair();
        ctl_rd = 1; step();
        look(0, 'h12345, 0, 0, 0, 0, "R4");
        look(1, 'h12345, 0, 0, 0, 0, "R4");
    endtask

    task automatic t_ctl_write();
        fill_pair();
        ctl_wr = 1; ctl_wdata = 32'h0000_1234; step();
        look(0, 'h12345, 1, 'hABCDE, 1, 0, "R5");
        look(1, 'h12345, 1, 'h11111, 0, 1, "R5");
        ctl_wr = 1; ctl_wdata = 32'h0; step();
        look(0, 'h12345, 0, 0, 0, 0, "R5");
        look(1, 'h12345, 1, 'h11111, 0, 1, "R5");
        do_fill(0, 'h12345, 'hABCDE, 1, 0);
        ctl_wr = 1; ctl_wdata = 32'h0000_8000; step();
        look(1, 'h12345, 0, 0, 0, 0, "R5");
        look(0, 'h12345, 1, 'hABCDE, 1, 0, "R5");
    endtask

    task automatic t_root();
        fill_pair();
        root_wr_user = 1; step();
        look(0, 'h12345, 0, 0, 0, 0, "R6");
        look(1, 'h12345, 1, 'h11111, 0, 1, "R6");
        do_fill(0, 'h12345, 'hABCDE, 1, 0);
        root_wr_super = 1; step();
        look(1, 'h12345, 0, 0, 0, 0, "R6");
        look(0, 'h12345, 1, 'hABCDE, 1, 0, "R6");
    endtask

    task automatic t_purge();
        fill_pair();
        do_fill(0, 'h00023, 'h00004, 0, 1);
        bus_wr = 1; bus_fc = 3'd1; bus_vpn = 'h12345; step();
        look(0, 'h12345, 1, 'hABCDE, 1, 0, "R7");
        look(1, 'h12345, 1, 'h11111, 0, 1, "R7");
        bus_wr = 1; bus_fc = 3'd3; bus_vpn = 'h00033; step();
        look(0, 'h00023, 1, 'h00004, 0, 1, "R7");
        bus_wr = 1; bus_fc = 3'd3; bus_vpn = 'h12345; step();
        look(0, 'h12345, 0, 0, 0, 0, "R7");
        look(1, 'h12345, 0, 0, 0, 0, "R7");
        look(0, 'h00023, 1, 'h00004, 0, 1, "R7");
    endtask

    task automatic t_race();
        set_fill(0, 'h00050, 'h00050, 0, 0); ctl_rd = 1; step();
        look(0, 'h00050, 0, 0, 0, 0, "R8");
        set_fill(1, 'h00060, 'h00060, 0, 0); root_wr_super = 1; step();
        look(1, 'h00060, 0, 0, 0, 0, "R8");
        set_fill(0, 'h00070, 'h00070, 0, 0);
        bus_wr = 1; bus_fc = 3'd3; bus_vpn = 'h00070; step();
        look(0, 'h00070, 0, 0, 0, 0, "R8");
        set_fill(0, 'h00070, 'h00077, 1, 1); root_wr_super = 1; step();
        look(0, 'h00070, 1, 'h00077, 1, 1, "R8");
        do_fill(0, 'h00023, 'h00004, 0, 0);
        set_fill(0, 'h00083, 'h00083, 0, 1);
        bus_wr = 1; bus_fc = 3'd3; bus_vpn = 'h00023; step();
        look(0, 'h00083, 1, 'h00083, 0, 1, "R8");
        look(0, 'h00023, 0, 0, 0, 0, "R8");
    endtask

    initial begin
        idle();
        lk_vpn = '0; lk_super = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_fill();
        t_index();
        t_ctl_read();
        t_ctl_write();
        t_root();
        t_purge();
        t_race();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule